// File: doc/BRIEF.md
# Flash Command Register Interface

This block is the control side of a byte-wide parallel flash memory as seen from its three active-low bus strobes (chip select, output enable, write strobe). Commands reach it as write cycles on the data bus. A small on-chip byte array stands in for the cell array, so program and erase results can be read back.

The write strobe is sampled on the system clock, and its falling and rising edges are found from the sampled value. An address is captured on a falling edge and a command or data byte on the rising edge. Some operations need two bus cycles: erase needs a repeated setup byte, and program needs a setup byte followed by an address-and-data cycle. Program and erase then run for a fixed number of clock cycles from an internal timer. The next write cycle ends them, and that cycle's byte is decoded as a new command, normally a verify. Reads return array bytes, identification bytes, or the byte at the latched verify address. All writes are refused while the programming-voltage flag is low.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write cycle is seen only while `ce_n` is low and `vpp_hi` is high. Its byte is taken from `din` at the clock edge where `we_n` is first sampled high after being low. With `vpp_hi` low, writes change nothing.
- R2: `dout_en` is high only while `ce_n` and `oe_n` are low, `we_n` is high, and no program or erase state is active. When `dout_en` is low, `dout` is 00h.
- R3: Reset leaves read mode with every byte at FFh. In read mode, `dout` is the byte at `addr`. Writing 00h, FFh or any byte without a meaning below selects read mode.
- R4: Writing 90h selects identification mode. A read returns 31h when `addr` bit 0 is 0 and BDh when it is 1.
- R5: An erase starts only when 20h is written in two write cycles in a row. If the second byte differs, it is decoded as its own command and no erase starts.
- R6: An erase that runs ERASE_CYCLES clock edges past its starting write edge sets every byte to FFh. If a write ends it sooner, byte i keeps its value when bit (i mod 32) of STUCK_PATTERN is 1 and becomes FFh otherwise. A stopping write on the expiry edge itself leaves the erase complete.
- R7: After 40h, the next write cycle is a data cycle. Its address comes from its falling edge and its data from its rising edge. After PROG_CYCLES edges, the byte becomes its old value AND the data. A write that ends it sooner leaves the byte unchanged. A stop on the expiry edge counts as complete.
- R8: Writing A0h latches the address from that cycle's falling edge. Writing C0h keeps the address from the last program cycle. In both verify modes, reads return the byte at the latched address, whatever `addr` holds.
- R9: Writing FFh twice during a program or erase aborts it, with the early-stop effect of R6 or R7, and leaves read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data and commands |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Data output drive enable |

## Verification
Two functions can fall in the same clock edge: the internal timer reaching its limit, and the rising write edge that stops the operation. The bench places the stopping verify command so that its rising edge lands exactly PROG_CYCLES or ERASE_CYCLES edges after the start, then reads back through verify and read mode. It judges the result against the completed outcome (the ANDed byte, or all bytes FFh). The same stop placed a few edges earlier must instead show the unchanged byte or the stuck-pattern subset.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W = 4,
  parameter int PROG_CYCLES = 8,
  parameter int ERASE_CYCLES = 20,
  parameter logic [31:0] STUCK_PATTERN = 32'h2A51_9C36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMAX  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    S_READ, S_SIG, S_ESET, S_ERASE, S_EVER, S_PSET, S_PROG, S_PVER
  } st_t;

  st_t st, nx;
  logic we_q, done;
  logic [ADDR_W-1:0] fall_a, lat_a;
  logic [7:0] lat_d, sel;
  logic [CNT_W-1:0] cnt;
  logic [7:0] mem [DEPTH];

  wire wr_ok   = !ce_n && vpp_hi;
  wire w_fall  = wr_ok && we_q && !we_n;
  wire w_rise  = wr_ok && !we_q && we_n;
  wire timed   = (st == S_ERASE) || (st == S_PROG);
  wire [CNT_W-1:0] last = (st == S_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
  wire lim_hit = timed && !done && (cnt == last);

  always_comb begin
    nx = st;
    if (w_rise) begin
      if (st == S_PSET) nx = S_PROG;
      else begin
        case (din)
          8'h90:   nx = S_SIG;
          8'h20:   nx = (st == S_ESET) ? S_ERASE : S_ESET;
          8'hA0:   nx = S_EVER;
          8'h40:   nx = S_PSET;
          8'hC0:   nx = S_PVER;
          default: nx = S_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_READ;
      we_q   <= 1'b1;
      fall_a <= '0;
      lat_a  <= '0;
      lat_d  <= 8'hFF;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      st   <= nx;
      we_q <= we_n;
      if (w_fall) fall_a <= addr;
      if (w_rise && (st == S_PSET || din == 8'hA0)) lat_a <= fall_a;
      if (w_rise && st == S_PSET) lat_d <= din;
      if (w_rise) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (lim_hit) done <= 1'b1;
      else if (timed && !done) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (lim_hit && st == S_ERASE) mem[i] <= 8'hFF;
        else if (w_rise && st == S_ERASE && !done && !STUCK_PATTERN[i % 32]) mem[i] <= 8'hFF;
        else if (lim_hit && st == S_PROG && lat_a == ADDR_W'(i)) mem[i] <= mem[i] & lat_d;
      end
    end
  end

  always_comb begin
    case (st)
      S_SIG:          sel = addr[0] ? 8'hBD : 8'h31;
      S_EVER, S_PVER: sel = mem[lat_a];
      default:        sel = mem[addr];
    endcase
  end

  assign dout_en = !ce_n && !oe_n && we_n && !timed;
  assign dout    = dout_en ? sel : 8'h00;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vpp_hi,
  input logic [2:0]        st,
  input logic [ADDR_W-1:0] lat_a,
  input logic              lim_hit,
  input logic              w_rise,
  input logic [7:0]        mem0,
  input logic [7:0]        mem_la
);
  localparam logic [2:0] C_ESET = 3'd2, C_ERASE = 3'd3, C_PROG = 3'd6, C_PVER = 3'd7;

  assert_vpp_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |=> st == $past(st));

  assert_erase_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == C_ERASE) |-> $past(st) == C_ESET);

  assert_erase_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ERASE && lim_hit) |=> mem0 == 8'hFF);

  assert_prog_clears_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_PROG && !w_rise) |=> $stable(lat_a) && ((mem_la & ~$past(mem_la)) == 8'h00));

  assert_verify_keeps_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == C_PVER) |-> $stable(lat_a));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .vpp_hi(vpp_hi), .st(st), .lat_a(lat_a),
  .lim_hit(lim_hit), .w_rise(w_rise), .mem0(mem[0]), .mem_la(mem[lat_a])
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_T = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PC = 8;
  localparam int EC = 20;
  localparam logic [31:0] STUCK = 32'h2A51_9C36;
  localparam int MD_READ = 0, MD_SIG = 1, MD_ESET = 2, MD_ERASE = 3,
                 MD_EVER = 4, MD_PSET = 5, MD_PROG = 6, MD_PVER = 7;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, vpp_hi = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;

  int chk_n = 0, err_n = 0;
  bit ended = 0;

  flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .STUCK_PATTERN(STUCK))
    i_flash_cmd_ctrl (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .vpp_hi(vpp_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  always #(CLK_T/2) clk = ~clk;

  int m_mode = MD_READ, m_cnt = 0, m_fall = 0, m_lat = 0, m_dat = 255;
  bit m_done = 0, m_weq = 1;
  int m_mem [DEPTH];
  bit rise, fall, tmd;
  int lim;
  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = MD_READ; m_cnt = 0; m_done = 0; m_weq = 1; m_fall = 0; m_lat = 0; m_dat = 255;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
    end else begin
      rise = !ce_n && vpp_hi && !m_weq && we_n;
      fall = !ce_n && vpp_hi && m_weq && !we_n;
      tmd  = (m_mode == MD_ERASE) || (m_mode == MD_PROG);
      lim  = (m_mode == MD_ERASE) ? EC : PC;
      if (tmd && !m_done) begin
        m_cnt++;
        if (m_cnt == lim) begin
          m_done = 1;
          if (m_mode == MD_ERASE) for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
          else m_mem[m_lat] = m_mem[m_lat] & m_dat;
        end else if (rise && m_mode == MD_ERASE)
          for (int i = 0; i < DEPTH; i++) if (!STUCK[i % 32]) m_mem[i] = 255;
      end
      if (fall) m_fall = int'(addr);
      if (rise) begin
        m_cnt = 0; m_done = 0;
        if (m_mode == MD_PSET) begin m_lat = m_fall; m_dat = int'(din); m_mode = MD_PROG; end
        else if (din == 8'h90) m_mode = MD_SIG;
        else if (din == 8'h20) m_mode = (m_mode == MD_ESET) ? MD_ERASE : MD_ESET;
        else if (din == 8'hA0) begin m_lat = m_fall; m_mode = MD_EVER; end
        else if (din == 8'h40) m_mode = MD_PSET;
        else if (din == 8'hC0) m_mode = MD_PVER;
        else m_mode = MD_READ;
      end
      m_weq = we_n;
    end
    #(CLK_T/4);
    begin
      bit e_en; int e_d; string tag;
      e_en = !ce_n && !oe_n && we_n && !(m_mode == MD_ERASE || m_mode == MD_PROG);
      tag = "R3";
      if (m_mode == MD_SIG) begin e_d = addr[0] ? 8'hBD : 8'h31; tag = "R4"; end
      else if (m_mode == MD_EVER || m_mode == MD_PVER) begin e_d = m_mem[m_lat]; tag = "R8"; end
      else e_d = m_mem[addr];
      if (!e_en) begin e_d = 0; tag = "R2"; end
      chk_n++;
      if (dout_en !== e_en || int'(dout) != e_d) begin
        err_n++;
        $display("FAIL %s per-cycle: got en=%0b d=%02h exp en=%0b d=%02h", tag, dout_en, dout, e_en, e_d);
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    chk_n++;
    if (got != exp) begin
      err_n++;
      $display("FAIL %s: got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int fa, input int d, input int ra);
    @(negedge clk); ce_n = 0; oe_n = 1; addr = AW'(fa); we_n = 0;
    @(negedge clk); we_n = 1; din = 8'(d); addr = AW'(ra);
    @(negedge clk); ce_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    #1;
    check(tag, int'(dout_en), 1);
    check(tag, int'(dout), exp);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", chk_n, err_n);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    err_n++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: standby output off; R3: reset contents
    #1; check("R2", int'(dout_en), 0);
    rd(3, 8'hFF, "R3");

    // R1: no write takes effect with vpp low
    vpp_hi = 0;
    wr(0, 8'h90, 0);
    rd(0, 8'hFF, "R1");
    wr(0, 8'h40, 0); wr(2, 8'h00, 2); idle(PC);
    rd(2, 8'hFF, "R1");
    vpp_hi = 1;

    // R4: identification
    wr(0, 8'h90, 0);
    rd(0, 8'h31, "R4"); rd(1, 8'hBD, "R4"); rd(3, 8'hBD, "R4");
    wr(0, 8'h00, 0);
    rd(0, 8'hFF, "R3");

    // R7/R8: program, address from falling edge
    wr(0, 8'h40, 0); wr(5, 8'hA5, 9);
    @(negedge clk); ce_n = 0; oe_n = 0; #1; check("R2", int'(dout_en), 0);
    ce_n = 1; oe_n = 1;
    idle(PC);
    wr(0, 8'hC0, 0);
    rd(0, 8'hA5, "R8");
    wr(0, 8'h00, 0);
    rd(5, 8'hA5, "R7"); rd(9, 8'hFF, "R7");
    wr(0, 8'h40, 0); wr(5, 8'h3C, 5); idle(PC); wr(0, 8'h00, 0);
    rd(5, 8'h24, "R7");
    // R7: early stop leaves byte
    wr(0, 8'h40, 0); wr(6, 8'h00, 6); idle(0); wr(0, 8'hC0, 0);
    rd(11, 8'hFF, "R7");
    // R7: stop on expiry edge completes
    wr(0, 8'h40, 0); wr(7, 8'h0F, 7); idle(PC - 3); wr(0, 8'hC0, 0);
    rd(2, 8'h0F, "R7");

    // R6/R8: full erase, verify address from falling edge
    wr(0, 8'h20, 0); wr(0, 8'h20, 0); idle(EC);
    wr(5, 8'hA0, 0);
    rd(0, 8'hFF, "R8");
    wr(0, 8'h00, 0);
    rd(7, 8'hFF, "R6");

    // R5: unconfirmed erase
    wr(0, 8'h40, 0); wr(3, 8'h00, 3); idle(PC);
    wr(0, 8'h20, 0); wr(0, 8'h00, 0); idle(EC + 2);
    rd(3, 8'h00, "R5");
    wr(0, 8'h20, 0); wr(0, 8'h90, 0);
    rd(0, 8'h31, "R5");
    wr(0, 8'h00, 0);
    rd(3, 8'h00, "R5");

    // R6: early erase stop leaves stuck subset
    for (int i = 0; i < DEPTH; i++) begin
      wr(0, 8'h40, 0); wr(i, 8'h00, 0); idle(PC);
    end
    wr(0, 8'h20, 0); wr(0, 8'h20, 0); idle(0); wr(0, 8'hA0, 0);
    wr(0, 8'h00, 0);
    for (int i = 0; i < DEPTH; i++) rd(i, STUCK[i % 32] ? 8'h00 : 8'hFF, "R6");
    // R6: stop on expiry edge completes
    wr(0, 8'h20, 0); wr(0, 8'h20, 0); idle(EC - 3); wr(0, 8'hA0, 0);
    wr(0, 8'h00, 0);
    for (int i = 0; i < DEPTH; i++) rd(i, 8'hFF, "R6");

    // R9: abort erase and program
    wr(0, 8'h40, 0); wr(2, 8'h00, 2); idle(PC);
    wr(0, 8'h20, 0); wr(0, 8'h20, 0); wr(0, 8'hFF, 0); wr(0, 8'hFF, 0);
    rd(2, 8'h00, "R9"); rd(0, 8'hFF, "R9");
    wr(0, 8'h40, 0); wr(4, 8'h00, 4); wr(0, 8'hFF, 0); wr(0, 8'hFF, 0);
    rd(4, 8'hFF, "R9");

    idle(2);
    finish_run();
  end
endmodule